// File: doc/BRIEF.md
# Smart Card Interrupt Cause Register

This block collects the interrupt causes of a smart card interface controller in one 8-bit register. The processor reads this register over a simple register bus. Event strobes come from the transmitter, the receiver, card detection, the supply timer and the wait timer. Each strobe sets its own sticky bit. The receive data bit instead follows the receive FIFO level. A per-bit enable mask, held outside the block, selects which bits may drive the single combined interrupt line. Masking affects only that line. Bits are still latched while they are masked.

Each bit has its own clear source:
- a read of this register;
- a read of the transmit-control register;
- a read of the receive-control register;
- for the receive data bit, the FIFO becoming empty.

A set event that arrives in the same cycle as a clearing read takes priority over the clear, so no event is lost.

The interface logic can be clock-gated or powered down. In that state every cause except the card event is ignored, while card insertion, removal and fault events are still recorded. In bypass mode the receive data bit changes meaning: it becomes a sticky flag raised by a falling edge on the card I/O line.

Top module: `sc_irq_status`

## Requirements
- R1: After reset, `status` is 8'h00 and `irq` is low.
- R2: The bit layout is wait timeout (7), card event (6), supply timer (5), receive data (4), transmit FIFO event (3), byte sent (2), transmit error (1) and receive error (0). Each bit appears on `status` one clock after its cause. A `rd_status` pulse clears bits 7, 6, 5 and 2 on the next clock and leaves bits 3, 1 and 0 unchanged.
- R3: Bit 3 sets when `tx_empty` or `tx_full` goes from low to high. Bit 1 sets on `tx_break` or `tx_underrun`. Both bits are cleared only by `rd_txctl`.
- R4: Bit 0 sets on `rx_overrun` or `rx_parity_err` and is cleared only by `rd_rxctl`.
- R5: When `bypass_mode` is low, bit 4 equals `rx_fifo_nempty` delayed by one clock, whatever reads occur.
- R6: When `bypass_mode` is high, bit 4 sets on a high-to-low transition of `card_io` and is cleared by `rd_status`. In this mode `rx_fifo_nempty` has no effect.
- R7: `tx_byte_done` sets bit 2, except when `block_mode` is low, `break_det_en` is high and `break_det` is high in the same cycle. In block mode (`block_mode` high) a check byte sets bit 2 like any other byte.
- R8: `irq` is high exactly when some bit is set in both `status` and `irq_en`. A masked event is still latched in `status`.
- R9: When a set event and the read that clears its bit occur in the same cycle, the bit is set afterwards.
- R10: While `logic_en` is low or `pwr_dn` is high, only `ev_card` can set a bit. All other event strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| logic_en | input | 1 | Interface logic clock enabled |
| pwr_dn | input | 1 | Interface power-down |
| bypass_mode | input | 1 | Receive data bit tracks I/O falling edges |
| block_mode | input | 1 | Block protocol (1) or character protocol (0) |
| break_det_en | input | 1 | Break detection enabled |
| ev_wait_to | input | 1 | Wait timeout strobe |
| ev_card | input | 1 | Card insert/remove/fault strobe |
| ev_vcc_tmr | input | 1 | Supply timer expiry strobe |
| tx_byte_done | input | 1 | Byte transmitted strobe |
| break_det | input | 1 | Break seen at end of the current byte |
| tx_empty | input | 1 | Transmit FIFO empty level |
| tx_full | input | 1 | Transmit FIFO full level |
| tx_break | input | 1 | Transmit break error strobe |
| tx_underrun | input | 1 | Transmit underrun strobe |
| rx_overrun | input | 1 | Receive overrun strobe |
| rx_parity_err | input | 1 | Receive parity error strobe |
| rx_fifo_nempty | input | 1 | Receive FIFO not empty level |
| card_io | input | 1 | Card I/O line, synchronised |
| rd_status | input | 1 | Read strobe of this register |
| rd_txctl | input | 1 | Read strobe of transmit-control register |
| rd_rxctl | input | 1 | Read strobe of receive-control register |
| irq_en | input | 8 | Per-bit interrupt enable |
| status | output | 8 | Interrupt cause register |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach are collisions between a cause and the read that clears its bit, and reads aimed at the wrong bits. Both show up only through bits that should survive or revive. A vector table therefore sequences events and the three different read strobes, with several bits set at once. This shows that each read clears only its own group, and that a read and an event in the same cycle leave the bit set. Directed tests then cover the level-driven and edge-driven cases: transmit FIFO edges that must not re-trigger on a held level, the break suppression rule, bypass I/O edges with the FIFO level held high, and events sent while the interface is gated.

// File: rtl/sc_irq_status.sv
module sc_irq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       logic_en,
  input  logic       pwr_dn,
  input  logic       bypass_mode,
  input  logic       block_mode,
  input  logic       break_det_en,
  input  logic       ev_wait_to,
  input  logic       ev_card,
  input  logic       ev_vcc_tmr,
  input  logic       tx_byte_done,
  input  logic       break_det,
  input  logic       tx_empty,
  input  logic       tx_full,
  input  logic       tx_break,
  input  logic       tx_underrun,
  input  logic       rx_overrun,
  input  logic       rx_parity_err,
  input  logic       rx_fifo_nempty,
  input  logic       card_io,
  input  logic       rd_status,
  input  logic       rd_txctl,
  input  logic       rd_rxctl,
  input  logic [7:0] irq_en,
  output logic [7:0] status,
  output logic       irq
);

  logic wait_q, card_q, vcc_q, rxdav_q, txevt_q, txsent_q, txerr_q, rxerr_q;
  logic empty_d, full_d, io_d;

  wire active   = logic_en & ~pwr_dn;
  wire suppress = ~block_mode & break_det_en & break_det;
  wire fifo_edge = (tx_empty & ~empty_d) | (tx_full & ~full_d);
  wire io_fall  = io_d & ~card_io;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q   <= 1'b0;
      card_q   <= 1'b0;
      vcc_q    <= 1'b0;
      rxdav_q  <= 1'b0;
      txevt_q  <= 1'b0;
      txsent_q <= 1'b0;
      txerr_q  <= 1'b0;
      rxerr_q  <= 1'b0;
      empty_d  <= 1'b0;
      full_d   <= 1'b0;
      io_d     <= 1'b1;
    end else begin
      empty_d  <= tx_empty;
      full_d   <= tx_full;
      io_d     <= card_io;
      wait_q   <= (active & ev_wait_to) | (wait_q & ~rd_status);
      card_q   <= ev_card | (card_q & ~rd_status);
      vcc_q    <= (active & ev_vcc_tmr) | (vcc_q & ~rd_status);
      txsent_q <= (active & tx_byte_done & ~suppress) | (txsent_q & ~rd_status);
      txevt_q  <= (active & fifo_edge) | (txevt_q & ~rd_txctl);
      txerr_q  <= (active & (tx_break | tx_underrun)) | (txerr_q & ~rd_txctl);
      rxerr_q  <= (active & (rx_overrun | rx_parity_err)) | (rxerr_q & ~rd_rxctl);
      if (bypass_mode) rxdav_q <= (active & io_fall) | (rxdav_q & ~rd_status);
      else             rxdav_q <= rx_fifo_nempty;
    end
  end

  assign status = {wait_q, card_q, vcc_q, rxdav_q, txevt_q, txsent_q, txerr_q, rxerr_q};
  assign irq    = |(status & irq_en);

endmodule

module sc_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       logic_en,
  input logic       pwr_dn,
  input logic       bypass_mode,
  input logic       ev_wait_to,
  input logic       ev_card,
  input logic       rx_fifo_nempty,
  input logic       rd_status,
  input logic       rd_txctl,
  input logic       rd_rxctl,
  input logic [7:0] status,
  input logic       irq
);
  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_quiet_chk: assert (status != 8'h00 || !irq);
    end
  end
  // R2
  wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !ev_wait_to |=> !status[7]);
  // R3
  txevt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] && !rd_txctl |=> status[3]);
  // R4
  rxerr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] && !rd_rxctl |=> status[0]);
  // R5
  rxdav_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_mode |=> status[4] == $past(rx_fifo_nempty));
  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status == 8'h00 |-> !irq);
  // R9
  card_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_card |=> status[6]);
  // R10
  gated_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!logic_en || pwr_dn) && !status[7] |=> !status[7]);
endmodule

bind sc_irq_status sc_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .logic_en(logic_en), .pwr_dn(pwr_dn),
  .bypass_mode(bypass_mode), .ev_wait_to(ev_wait_to), .ev_card(ev_card),
  .rx_fifo_nempty(rx_fifo_nempty), .rd_status(rd_status), .rd_txctl(rd_txctl),
  .rd_rxctl(rd_rxctl), .status(status), .irq(irq)
);

// File: tb/sc_irq_status_tb.sv
`timescale 1ns/1ps
module sc_irq_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic logic_en = 1'b1, pwr_dn = 1'b0, bypass_mode = 1'b0, block_mode = 1'b0, break_det_en = 1'b0;
  logic ev_wait_to = 0, ev_card = 0, ev_vcc_tmr = 0, tx_byte_done = 0, break_det = 0;
  logic tx_empty = 0, tx_full = 0, tx_break = 0, tx_underrun = 0, rx_overrun = 0, rx_parity_err = 0;
  logic rx_fifo_nempty = 0, card_io = 1;
  logic rd_status = 0, rd_txctl = 0, rd_rxctl = 0;
  logic [7:0] irq_en = 8'h00;
  logic [7:0] status;
  logic irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sc_irq_status u_dut (.*);

  // {wait, card, vcc, txdone, brk, undr, ovr, par, rdS, rdT, rdR, expected status}
  localparam logic [18:0] VEC [16] = '{
    {11'b10000000000, 8'h80}, {11'b01000000000, 8'hC0},
    {11'b00100000000, 8'hE0}, {11'b00010000000, 8'hE4},
    {11'b00000010000, 8'hE5}, {11'b00001000000, 8'hE7},
    {11'b00000000100, 8'h03}, {11'b00000000010, 8'h01},
    {11'b00000001000, 8'h01}, {11'b00000000001, 8'h00},
    {11'b00000100000, 8'h02}, {11'b00000000100, 8'h02},
    {11'b00000000001, 8'h02}, {11'b00000000010, 8'h00},
    {11'b10000000100, 8'h80}, {11'b00000000100, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    {ev_wait_to, ev_card, ev_vcc_tmr, tx_byte_done, tx_break, tx_underrun,
     rx_overrun, rx_parity_err, rd_status, rd_txctl, rd_rxctl} = '0;
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 status", status, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    cyc();

    // R2 R3 R4 R9 via table
    for (int i = 0; i < 16; i++) begin
      {ev_wait_to, ev_card, ev_vcc_tmr, tx_byte_done, tx_break, tx_underrun,
       rx_overrun, rx_parity_err, rd_status, rd_txctl, rd_rxctl} = VEC[i][18:8];
      cyc();
      chk($sformatf("R2/R3/R4/R9 vector %0d", i), status, VEC[i][7:0]);
    end

    // R3 transmit FIFO edges
    tx_empty = 1; cyc();
    chk("R3 empty edge", status, 8'h08);
    rd_status = 1; cyc();
    chk("R3 status read keeps", status, 8'h08);
    rd_txctl = 1; cyc(); cyc();
    chk("R3 held level no retrigger", status, 8'h00);
    tx_full = 1; cyc();
    chk("R3 full edge", status, 8'h08);
    rd_txctl = 1; tx_empty = 0; tx_full = 0; cyc();
    chk("R3 txctl clear", status, 8'h00);

    // R5 FIFO level
    rx_fifo_nempty = 1; cyc();
    chk("R5 level up", status, 8'h10);
    rd_status = 1; rd_rxctl = 1; cyc();
    chk("R5 reads ignored", status, 8'h10);
    rx_fifo_nempty = 0; cyc();
    chk("R5 level down", status, 8'h00);

    // R6 bypass
    bypass_mode = 1; cyc();
    card_io = 0; cyc();
    chk("R6 io fall", status, 8'h10);
    card_io = 1; rx_fifo_nempty = 1; rd_status = 1; cyc(); cyc();
    chk("R6 read clears, fifo ignored", status, 8'h00);
    bypass_mode = 0; rx_fifo_nempty = 0; cyc();

    // R7 break suppression
    break_det_en = 1; break_det = 1; tx_byte_done = 1; cyc();
    chk("R7 suppressed", status, 8'h00);
    block_mode = 1; tx_byte_done = 1; cyc();
    chk("R7 block mode sets", status, 8'h04);
    rd_status = 1; block_mode = 0; break_det = 0; break_det_en = 0; cyc();

    // R8 mask
    ev_wait_to = 1; cyc();
    chk("R8 masked latched", status, 8'h80);
    chk("R8 masked irq low", {7'd0, irq}, 8'h00);
    irq_en = 8'h80; #1;
    chk("R8 enabled irq high", {7'd0, irq}, 8'h01);
    irq_en = 8'h7F; #1;
    chk("R8 other bits irq low", {7'd0, irq}, 8'h00);
    rd_status = 1; irq_en = 8'h00; cyc();

    // R10 gating
    logic_en = 0;
    ev_wait_to = 1; ev_vcc_tmr = 1; tx_byte_done = 1; rx_overrun = 1; tx_break = 1; cyc();
    chk("R10 gated ignored", status, 8'h00);
    ev_card = 1; cyc();
    chk("R10 card latches gated", status, 8'h40);
    rd_status = 1; cyc();
    logic_en = 1; pwr_dn = 1; ev_wait_to = 1; ev_card = 1; cyc();
    chk("R10 power-down", status, 8'h40);
    pwr_dn = 0; rd_status = 1; cyc();
    chk("R10 cleared", status, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule